// File: doc/BRIEF.md
# Four-Entry Pseudo-LRU Replacement Tracker

This block keeps the replacement order of a small, fully associative instruction translation buffer with four entries. The order lives in a 6-bit field at bits 31:26 of the MMU control register. Each bit of the field records which of two entries was used more recently. The surrounding logic feeds the current register value in. It takes the updated value back, with the field rewritten on every use of an entry.

A hit on entry k applies a fixed set/clear pattern to the field. On a miss, the field is decoded to pick a victim entry. When the unified translation buffer supplies a matching entry for that miss, the block issues a refill strobe for the victim slot one cycle later. In the same cycle as the miss it also marks that slot as used in the returned register value. A field value that names no victim raises a flag and falls back to entry 0.

Top module: `plru4_tracker`

## Requirements
- R1: `mmu_ctl_o[25:0]` always equals `mmu_ctl_i[25:0]`. The field is L[5:0] = `mmu_ctl_i[31:26]`, so L[i] sits at register bit 26+i.
- R2: A use of entry 0 returns L[5], L[4] and L[3] cleared. The other field bits are kept.
- R3: A use of entry 1 returns L[5] set and L[2], L[1] cleared. The other field bits are kept.
- R4: A use of entry 2 returns L[4], L[2] set and L[0] cleared. The other field bits are kept.
- R5: A use of entry 3 returns L[3], L[1] and L[0] set. The other field bits are kept.
- R6: `victim_idx` is decoded from the input field, and the first matching test wins, in this order. Entry 0 if L[5:3]=111. Entry 1 if L[5]=0, L[2]=1 and L[1]=1. Entry 2 if L[4]=0, L[2]=0 and L[0]=1. Entry 3 if L[3], L[1] and L[0] are 0.
- R7: A field that matches none of the R6 tests drives `illegal_state` high and `victim_idx` to 0. Otherwise `illegal_state` is low.
- R8: With `miss_valid` and `utlb_hit` high and `hit_valid` low, `mmu_ctl_o` applies the use pattern of `victim_idx` in the same cycle. On the next cycle `refill_we` is high and `refill_slot` equals that victim.
- R9: `hit_valid` takes priority over a miss, and the use applies to `hit_idx` with no refill. A miss without `utlb_hit`, or an idle cycle, returns the field unchanged and issues no refill.
- R10: While `rst_n` is low, and in the first cycle after reset, `refill_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_ctl_i | input | 32 | Current control register value |
| hit_valid | input | 1 | Lookup hit in the four-entry buffer |
| hit_idx | input | 2 | Entry that hit |
| miss_valid | input | 1 | Lookup missed in the four-entry buffer |
| utlb_hit | input | 1 | Unified buffer holds a match for the miss |
| mmu_ctl_o | output | 32 | Control register value with updated order field |
| victim_idx | output | 2 | Entry to replace, decoded from the input field |
| illegal_state | output | 1 | Input field matches no victim pattern |
| refill_we | output | 1 | Copy the unified entry into `refill_slot` |
| refill_slot | output | 2 | Slot that receives the copy |

## Verification
The updated register value, the victim index and the illegal flag are combinational, so they are due in the same cycle as their inputs. The bench drives each input set just after a falling edge and samples these outputs a moment later. The refill strobe and slot pass through one register, so they are due one rising edge after the qualifying miss. The bench keeps the expected strobe and slot from the previous cycle and compares them at the next falling edge. Directed field values cover every victim pattern, an illegal value and each entry's use. Random input sets then run against the behavioural model on every clock.

// File: rtl/plru4_tracker.sv
module plru4_tracker #(
  parameter int CTL_W     = 32,
  parameter int FIELD_LSB = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] mmu_ctl_i,
  input  logic             hit_valid,
  input  logic [1:0]       hit_idx,
  input  logic             miss_valid,
  input  logic             utlb_hit,
  output logic [CTL_W-1:0] mmu_ctl_o,
  output logic [1:0]       victim_idx,
  output logic             illegal_state,
  output logic             refill_we,
  output logic [1:0]       refill_slot
);
  localparam int FW = 6;

  logic [FW-1:0] lru, lru_nxt;
  logic          do_refill, use_en;
  logic [1:0]    use_idx;

  assign lru = mmu_ctl_i[FIELD_LSB +: FW];

  always_comb begin
    illegal_state = 1'b0;
    if (lru[5] & lru[4] & lru[3])          victim_idx = 2'd0;
    else if (!lru[5] & lru[2] & lru[1])    victim_idx = 2'd1;
    else if (!lru[4] & !lru[2] & lru[0])   victim_idx = 2'd2;
    else if (!lru[3] & !lru[1] & !lru[0])  victim_idx = 2'd3;
    else begin
      victim_idx    = 2'd0;
      illegal_state = 1'b1;
    end
  end

  assign do_refill = miss_valid & utlb_hit & ~hit_valid;
  assign use_en    = hit_valid | do_refill;
  assign use_idx   = hit_valid ? hit_idx : victim_idx;

  always_comb begin
    lru_nxt = lru;
    if (use_en) begin
      case (use_idx)
        2'd0: lru_nxt[5:3] = 3'b000;
        2'd1: begin lru_nxt[5] = 1'b1; lru_nxt[2:1] = 2'b00; end
        2'd2: begin lru_nxt[4] = 1'b1; lru_nxt[2] = 1'b1; lru_nxt[0] = 1'b0; end
        default: begin lru_nxt[3] = 1'b1; lru_nxt[1:0] = 2'b11; end
      endcase
    end
  end

  always_comb begin
    mmu_ctl_o = mmu_ctl_i;
    mmu_ctl_o[FIELD_LSB +: FW] = lru_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      refill_we   <= 1'b0;
      refill_slot <= 2'd0;
    end else begin
      refill_we   <= do_refill;
      refill_slot <= do_refill ? victim_idx : refill_slot;
    end
  end
endmodule

module plru4_tracker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] mmu_ctl_i,
  input logic        hit_valid,
  input logic [1:0]  hit_idx,
  input logic        miss_valid,
  input logic        utlb_hit,
  input logic [31:0] mmu_ctl_o,
  input logic [1:0]  victim_idx,
  input logic        illegal_state,
  input logic        refill_we,
  input logic [1:0]  refill_slot
);
  a_r1_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_ctl_o[25:0] == mmu_ctl_i[25:0]);
  a_r2_entry0_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_idx == 2'd0) |-> !(&mmu_ctl_o[31:29]));
  a_r5_entry3_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && hit_idx == 2'd3) |-> (mmu_ctl_o[29] && mmu_ctl_o[26]));
  a_r7_illegal_picks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_state |-> victim_idx == 2'd0);
  a_r8_refill_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && utlb_hit && !hit_valid) |=> (refill_we && refill_slot == $past(victim_idx)));
  a_r9_no_spurious_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_valid || !utlb_hit || hit_valid) |=> !refill_we);
  a_r9_idle_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_valid && !(miss_valid && utlb_hit)) |-> mmu_ctl_o == mmu_ctl_i);
endmodule

bind plru4_tracker plru4_tracker_chk chk (
  .clk(clk), .rst_n(rst_n), .mmu_ctl_i(mmu_ctl_i), .hit_valid(hit_valid),
  .hit_idx(hit_idx), .miss_valid(miss_valid), .utlb_hit(utlb_hit),
  .mmu_ctl_o(mmu_ctl_o), .victim_idx(victim_idx), .illegal_state(illegal_state),
  .refill_we(refill_we), .refill_slot(refill_slot)
);

// File: tb/plru4_tracker_test.sv
module plru4_tracker_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mmu_ctl_i;
  logic        hit_valid, miss_valid, utlb_hit;
  logic [1:0]  hit_idx;
  logic [31:0] mmu_ctl_o;
  logic [1:0]  victim_idx, refill_slot;
  logic        illegal_state, refill_we;

  int n_tests = 0;
  int n_fail  = 0;
  bit exp_we = 0;
  int exp_slot = 0;

  always #(PERIOD/2) clk = ~clk;

  plru4_tracker uut (
    .clk(clk), .rst_n(rst_n), .mmu_ctl_i(mmu_ctl_i), .hit_valid(hit_valid),
    .hit_idx(hit_idx), .miss_valid(miss_valid), .utlb_hit(utlb_hit),
    .mmu_ctl_o(mmu_ctl_o), .victim_idx(victim_idx), .illegal_state(illegal_state),
    .refill_we(refill_we), .refill_slot(refill_slot)
  );

  task automatic check(string req, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural model: victim, -1 when no pattern matches
  function automatic int model_victim(bit [5:0] f);
    if (f[5] && f[4] && f[3]) return 0;
    if (!f[5] && f[2] && f[1]) return 1;
    if (!f[4] && !f[2] && f[0]) return 2;
    if (!f[3] && !f[1] && !f[0]) return 3;
    return -1;
  endfunction

  function automatic bit [5:0] model_use(bit [5:0] f, int k);
    bit [5:0] r = f;
    if (k == 0) begin r[5] = 0; r[4] = 0; r[3] = 0; end
    if (k == 1) begin r[5] = 1; r[2] = 0; r[1] = 0; end
    if (k == 2) begin r[4] = 1; r[2] = 1; r[0] = 0; end
    if (k == 3) begin r[3] = 1; r[1] = 1; r[0] = 1; end
    return r;
  endfunction

  task automatic step(bit [31:0] ctl, bit hv, bit [1:0] hi, bit mv, bit uh);
    int v, vs, k;
    bit [5:0] f;
    @(negedge clk);
    check("R8 refill_we", refill_we, exp_we);
    if (exp_we) check("R8 refill_slot", refill_slot, exp_slot);
    mmu_ctl_i = ctl; hit_valid = hv; hit_idx = hi; miss_valid = mv; utlb_hit = uh;
    #1;
    f  = ctl[31:26];
    v  = model_victim(f);
    vs = (v < 0) ? 0 : v;
    check("R6 victim_idx", victim_idx, vs);
    check("R7 illegal_state", illegal_state, (v < 0));
    check("R1 low bits", mmu_ctl_o[25:0], ctl[25:0]);
    k = hv ? int'(hi) : ((mv && uh) ? vs : -1);
    if (k < 0) check("R9 field unchanged", mmu_ctl_o[31:26], f);
    else if (k == 0) check("R2 use entry 0", mmu_ctl_o[31:26], model_use(f, 0));
    else if (k == 1) check("R3 use entry 1", mmu_ctl_o[31:26], model_use(f, 1));
    else if (k == 2) check("R4 use entry 2", mmu_ctl_o[31:26], model_use(f, 2));
    else check("R5 use entry 3", mmu_ctl_o[31:26], model_use(f, 3));
    exp_we   = !hv && mv && uh;
    exp_slot = vs;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; mmu_ctl_i = 0; hit_valid = 0; hit_idx = 0; miss_valid = 1; utlb_hit = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset refill_we", refill_we, 0);
    miss_valid = 0; utlb_hit = 0;
    rst_n = 1;
    @(negedge clk);
    check("R10 after reset", refill_we, 0);
    // victim patterns and illegal value
    step({6'b111000, 26'h155_5555}, 0, 0, 0, 0);
    step({6'b000110, 26'h0ab_cdef}, 0, 0, 0, 0);
    step({6'b100001, 26'h3ff_ffff}, 0, 0, 0, 0);
    step({6'b100000, 26'h000_0000}, 0, 0, 0, 0);
    step({6'b110001, 26'h123_4567}, 0, 0, 1, 1);
    // each entry hit, hit over miss
    for (int k = 0; k < 4; k++) step({6'b010101, 26'h2aa_aaaa}, 1, 2'(k), 0, 0);
    for (int k = 0; k < 4; k++) step({6'b101010, 26'h155_5555}, 1, 2'(k), 1, 1);
    // refills to each victim, miss without unified hit
    step({6'b111000, 26'h0}, 0, 0, 1, 1);
    step({6'b000110, 26'h1}, 0, 0, 1, 1);
    step({6'b100001, 26'h2}, 0, 0, 1, 1);
    step({6'b100000, 26'h3}, 0, 0, 1, 1);
    step({6'b100000, 26'h4}, 0, 0, 1, 0);
    step({6'b100000, 26'h5}, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++)
      step($urandom, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    step(32'h0, 0, 0, 0, 0);
    finish_run();
  end
endmodule